// File: doc/BRIEF.md
# Shared-Trie Longest-Prefix-Match Pipeline

This block finds the longest matching route for a destination address on behalf of one of several virtual forwarding instances, all of which share one binary trie. The trie is split by level: level k lives in the memory of pipeline stage k, and each stage consumes one address bit, most significant first. A node can mark the end of a prefix for any subset of the instances. Such a node names a row of a next-hop table that holds one column per instance. Routes are never pushed down to leaves. Each stage therefore carries forward the row of the deepest node seen so far that holds a route for the request's instance. A final stage reads that row at the instance's column.

Requests enter through a valid/ready handshake. There are two kinds of request. A lookup carries an instance number and an address. A write bubble carries up to one node write for every trie stage and one next-hop entry write. A bubble moves down the pipeline in a slot of its own, so a route change costs exactly one slot. It gives no result. Results leave in request order, one per cycle, through a second valid/ready handshake.

Top module: `trie_lpm`

## Requirements
- R1: After reset, outValid is 0, inReady is 1, and every node and next-hop entry is zero, so any lookup returns outHit=0 with outNextHop=0.
- R2: A lookup returns the next hop of the deepest reachable node, at depth d (0..7), whose presence bit for the instance is set. A depth-d node matches the top d address bits, and depth 0 is the default route.
- R3: The next hop is the entry at column inInst of the row that the selected node names. Other instances' entries in that row never appear in the result.
- R4: A node whose presence bit for the request's instance is clear leaves the carried match unchanged, even if it holds routes for other instances.
- R5: If the address bit picks a child whose valid bit is clear, descent stops and the match already found is kept. With no match, the result is outHit=0 and outNextHop=0.
- R6: One request is accepted per cycle while the output is not stalled. A lookup accepted at a clock edge gives outValid after the 9th edge, counting that edge (STAGES+1 registers). Back-to-back lookups come out on consecutive cycles.
- R7: Results leave in the order their lookups were accepted, under any mix of lookups, bubbles and output stalls.
- R8: A write bubble (inIsWrite=1) takes one slot and gives no output. At each stage k with wrEn[k] set it writes node wrNode[k] at address wrAddr[k]. At the end it writes nhaVal into row nhaIdx, column nhaInst, when nhaEn is set. Lookups accepted before the bubble see the old contents and lookups accepted after it see the new.
- R9: While outValid=1 and outReady=0, outValid, outHit and outNextHop hold, inReady is 0, and no request is lost.
- R10: A node word is 19 bits, from MSB: left-child valid [18], right-child valid [17], child base [16:10], presence bits per instance [9:6] (instance i at bit 6+i), next-hop row [5:0]. Address bit 0 selects child base, bit 1 selects child base+1. Field k of wrNode is bits [19k+18:19k] and field k of wrAddr is bits [7k+6:7k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Request accepted on this edge when inValid is high |
| inIsWrite | input | 1 | 1: write bubble, 0: lookup |
| inInst | input | 2 | Instance of a lookup |
| inAddr | input | 8 | Destination address of a lookup |
| wrEn | input | 8 | Per-stage node write enable of a bubble |
| wrAddr | input | 56 | Per-stage node address, 7 bits per stage |
| wrNode | input | 152 | Per-stage node word, 19 bits per stage |
| nhaEn | input | 1 | Bubble writes one next-hop entry |
| nhaIdx | input | 6 | Next-hop row to write |
| nhaInst | input | 2 | Next-hop column to write |
| nhaVal | input | 8 | Next-hop value, 0 meaning no route |
| outValid | output | 1 | Lookup result present |
| outReady | input | 1 | Consumer takes the result |
| outHit | output | 1 | A route was found |
| outNextHop | output | 8 | Resolved next hop, 0 on a miss |

## Verification
Two things can meet in the same stage cycle: a node write carried by a bubble, and a lookup reading that stage's memory in the slot right next to the bubble. The bench sends a lookup, a bubble that adds a route on that lookup's path, and the same lookup again, all on consecutive cycles. The first result must show the old trie and the second must show the new route. The randomised phase repeats this race many times, with output stalls that freeze the pipeline while a bubble is inside it. Each result is compared with a software longest-match model that is updated when the bubble is issued.

// File: rtl/trie_lpm_pkg.sv
package trie_lpm_pkg;
  localparam int STAGES     = 8;
  localparam int ADDR_W     = STAGES;
  localparam int NODE_DEPTH = 128;
  localparam int NAW        = $clog2(NODE_DEPTH);
  localparam int NUM_INST   = 4;
  localparam int IW         = $clog2(NUM_INST);
  localparam int NHA_DEPTH  = 64;
  localparam int XAW        = $clog2(NHA_DEPTH);
  localparam int NH_W       = 8;
  localparam int NODE_W     = 2 + NAW + NUM_INST + XAW;

  typedef struct packed {
    logic                lValid;
    logic                rValid;
    logic [NAW-1:0]      childBase;
    logic [NUM_INST-1:0] present;
    logic [XAW-1:0]      nhaIdx;
  } node_t;

  typedef struct packed {
    logic                        valid;
    logic                        isWrite;
    logic [IW-1:0]               inst;
    logic [ADDR_W-1:0]           addr;
    logic [NAW-1:0]              nodeAddr;
    logic                        alive;
    logic                        hasBest;
    logic [XAW-1:0]              best;
    logic [STAGES-1:0]           wrEn;
    logic [STAGES-1:0][NAW-1:0]  wrAddr;
    node_t [STAGES-1:0]          wrNode;
    logic                        nhaEn;
    logic [XAW-1:0]              nhaIdx;
    logic [IW-1:0]               nhaInst;
    logic [NH_W-1:0]             nhaVal;
  } slot_t;

  typedef struct packed {
    logic advance;
    logic load;
  } strobe_t;
endpackage

// File: rtl/trie_lpm_level.sv
module trie_lpm_level
  import trie_lpm_pkg::*;
#(
  parameter int LEVEL = 0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  advance,
  input  slot_t slotIn,
  output slot_t slotOut
);
  node_t nodeMem [NODE_DEPTH];
  node_t node;
  logic  bitSel;
  logic  doWrite;
  slot_t nextSlot;

  assign node    = nodeMem[slotIn.nodeAddr];
  assign bitSel  = slotIn.addr[ADDR_W-1-LEVEL];
  assign doWrite = slotIn.valid && slotIn.isWrite && slotIn.wrEn[LEVEL];

  always_comb begin
    nextSlot = slotIn;
    if (slotIn.valid && !slotIn.isWrite && slotIn.alive) begin
      if (node.present[slotIn.inst]) begin
        nextSlot.hasBest = 1'b1;
        nextSlot.best    = node.nhaIdx;
      end
      if (bitSel ? node.rValid : node.lValid) begin
        nextSlot.nodeAddr = node.childBase + NAW'(bitSel);
      end else begin
        nextSlot.alive = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slotOut <= '0;
      for (int i = 0; i < NODE_DEPTH; i++) nodeMem[i] <= '0;
    end else if (advance) begin
      slotOut <= nextSlot;
      if (doWrite) nodeMem[slotIn.wrAddr[LEVEL]] <= slotIn.wrNode[LEVEL];
    end
  end
endmodule

// File: rtl/trie_lpm_ctrl.sv
module trie_lpm_ctrl
  import trie_lpm_pkg::*;
(
  input  logic    inValid,
  input  logic    outValid,
  input  logic    outReady,
  output logic    inReady,
  output strobe_t ctl
);
  always_comb begin
    ctl.advance = !outValid || outReady;
    ctl.load    = inValid && ctl.advance;
    inReady     = ctl.advance;
  end
endmodule

// File: rtl/trie_lpm_datapath.sv
module trie_lpm_datapath
  import trie_lpm_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  strobe_t                    ctl,
  input  logic                       reqIsWrite,
  input  logic [IW-1:0]              reqInst,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic [STAGES-1:0]          wrEn,
  input  logic [STAGES-1:0][NAW-1:0] wrAddr,
  input  node_t [STAGES-1:0]         wrNode,
  input  logic                       nhaEn,
  input  logic [XAW-1:0]             nhaIdx,
  input  logic [IW-1:0]              nhaInst,
  input  logic [NH_W-1:0]            nhaVal,
  output logic                       outValid,
  output logic                       outHit,
  output logic [NH_W-1:0]            outNextHop
);
  slot_t chain [STAGES+1];
  slot_t last;
  logic [NH_W-1:0] nhaTab [NHA_DEPTH][NUM_INST];
  logic [NH_W-1:0] entry;

  always_comb begin
    chain[0]          = '0;
    chain[0].valid    = ctl.load;
    chain[0].isWrite  = reqIsWrite;
    chain[0].inst     = reqInst;
    chain[0].addr     = reqAddr;
    chain[0].alive    = 1'b1;
    chain[0].wrEn     = wrEn;
    chain[0].wrAddr   = wrAddr;
    chain[0].wrNode   = wrNode;
    chain[0].nhaEn    = nhaEn;
    chain[0].nhaIdx   = nhaIdx;
    chain[0].nhaInst  = nhaInst;
    chain[0].nhaVal   = nhaVal;
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_level
    trie_lpm_level #(.LEVEL(k)) u_level (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (ctl.advance),
      .slotIn  (chain[k]),
      .slotOut (chain[k+1])
    );
  end

  assign last  = chain[STAGES];
  assign entry = nhaTab[last.best][last.inst];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid   <= 1'b0;
      outHit     <= 1'b0;
      outNextHop <= '0;
      for (int r = 0; r < NHA_DEPTH; r++)
        for (int c = 0; c < NUM_INST; c++) nhaTab[r][c] <= '0;
    end else if (ctl.advance) begin
      outValid   <= last.valid && !last.isWrite;
      outHit     <= last.hasBest && (entry != '0);
      outNextHop <= last.hasBest ? entry : '0;
      if (last.valid && last.isWrite && last.nhaEn)
        nhaTab[last.nhaIdx][last.nhaInst] <= last.nhaVal;
    end
  end
endmodule

// File: rtl/trie_lpm.sv
module trie_lpm
  import trie_lpm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic                     inIsWrite,
  input  logic [IW-1:0]            inInst,
  input  logic [ADDR_W-1:0]        inAddr,
  input  logic [STAGES-1:0]        wrEn,
  input  logic [STAGES*NAW-1:0]    wrAddr,
  input  logic [STAGES*NODE_W-1:0] wrNode,
  input  logic                     nhaEn,
  input  logic [XAW-1:0]           nhaIdx,
  input  logic [IW-1:0]            nhaInst,
  input  logic [NH_W-1:0]          nhaVal,
  output logic                     outValid,
  input  logic                     outReady,
  output logic                     outHit,
  output logic [NH_W-1:0]          outNextHop
);
  strobe_t                    ctl;
  logic [STAGES-1:0][NAW-1:0] wrAddrArr;
  node_t [STAGES-1:0]         wrNodeArr;

  assign wrAddrArr = wrAddr;
  assign wrNodeArr = wrNode;

  trie_lpm_ctrl u_ctrl (
    .inValid  (inValid),
    .outValid (outValid),
    .outReady (outReady),
    .inReady  (inReady),
    .ctl      (ctl)
  );

  trie_lpm_datapath u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .reqIsWrite (inIsWrite),
    .reqInst    (inInst),
    .reqAddr    (inAddr),
    .wrEn       (wrEn),
    .wrAddr     (wrAddrArr),
    .wrNode     (wrNodeArr),
    .nhaEn      (nhaEn),
    .nhaIdx     (nhaIdx),
    .nhaInst    (nhaInst),
    .nhaVal     (nhaVal),
    .outValid   (outValid),
    .outHit     (outHit),
    .outNextHop (outNextHop)
  );
endmodule

// File: rtl/trie_lpm_checker.sv
module trie_lpm_checker
  import trie_lpm_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            inValid,
  input logic            inReady,
  input logic            inIsWrite,
  input logic            outValid,
  input logic            outReady,
  input logic            outHit,
  input logic [NH_W-1:0] outNextHop
);
  logic [4:0] pending;
  logic       acc;
  logic       del;

  assign acc = inValid && inReady && !inIsWrite;
  assign del = outValid && outReady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= pending + 5'(acc) - 5'(del);
  end

  // R9: a stalled result stays put
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(outNextHop) && $stable(outHit));

  // R9: no request taken while the output is stalled
  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |-> !inReady);

  // R5: a miss always reports next hop zero
  assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outHit |-> outNextHop == '0);

  // R8: every result belongs to an accepted lookup, never to a bubble
  assert_no_orphan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> pending != '0);

  // R6: in-flight lookups bounded by the register count
  assert_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= 5'(STAGES + 1));
endmodule

bind trie_lpm trie_lpm_checker u_chk (.*);

// File: tb/trie_lpm_bench.sv
module trie_lpm_bench;
  import trie_lpm_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0, inIsWrite = 1'b0, nhaEn = 1'b0, outReady;
  logic [IW-1:0] inInst = '0, nhaInst = '0;
  logic [ADDR_W-1:0] inAddr = '0;
  logic [STAGES-1:0] wrEn = '0;
  logic [STAGES*NAW-1:0] wrAddr = '0;
  logic [STAGES*NODE_W-1:0] wrNode = '0;
  logic [XAW-1:0] nhaIdx = '0;
  logic [NH_W-1:0] nhaVal = '0;
  logic inReady, outValid, outHit;
  logic [NH_W-1:0] outNextHop;

  trie_lpm u_trie_lpm (.*);

  always #10 clk = ~clk;  // 50 MHz

  int total = 0, bad = 0, cyc = 0, pops = 0, issued = 0;
  bit holdReady = 0, jitter = 0;
  int expQ[$];
  string tagQ[$];
  int popAt[$];

  byte unsigned rt[NUM_INST][STAGES][NODE_DEPTH];
  bit [NODE_W-1:0] shadow[STAGES][NODE_DEPTH];
  bit hasIdx[STAGES][NODE_DEPTH];
  int idxOf[STAGES][NODE_DEPTH];
  int nextIdx = 0;

  typedef struct packed {
    bit       isLookup;
    bit [1:0] inst;
    bit [3:0] len;
    bit [7:0] addr;
    bit [7:0] val;
    bit [3:0] req;
  } vec_t;

  localparam vec_t VECS[13] = '{
    '{1'b0, 2'd0, 4'd0, 8'h00, 8'd10, 4'd2},  // default route inst0
    '{1'b0, 2'd0, 4'd3, 8'hA0, 8'd20, 4'd2},  // 101/3 inst0
    '{1'b0, 2'd1, 4'd5, 8'hA8, 8'd30, 4'd3},  // 10101/5 inst1
    '{1'b0, 2'd2, 4'd7, 8'hA8, 8'd40, 4'd10}, // 1010100/7 inst2
    '{1'b1, 2'd0, 4'd0, 8'hAB, 8'd20, 4'd4},  // R4: depth-5 node has inst1 only
    '{1'b1, 2'd1, 4'd0, 8'hAF, 8'd30, 4'd3},  // R3
    '{1'b1, 2'd2, 4'd0, 8'hA9, 8'd40, 4'd10}, // R10 R2: deepest level, right/left child select
    '{1'b1, 2'd2, 4'd0, 8'hAB, 8'd0,  4'd5},  // R5: missing child at depth 7
    '{1'b1, 2'd0, 4'd0, 8'h10, 8'd10, 4'd5},  // R5: missing left child at root
    '{1'b1, 2'd3, 4'd0, 8'hA8, 8'd0,  4'd3},  // R3: instance with no routes
    '{1'b0, 2'd0, 4'd0, 8'h00, 8'd0,  4'd4},  // delete default inst0
    '{1'b1, 2'd0, 4'd0, 8'h10, 8'd0,  4'd5},  // R5: no match left
    '{1'b1, 2'd0, 4'd0, 8'hA1, 8'd20, 4'd2}   // R2
  };

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int refLpm(int inst, int addr);
    int res = 0;
    for (int d = 0; d < STAGES; d++)
      if (rt[inst][d][addr >> (STAGES - d)] != 0) res = rt[inst][d][addr >> (STAGES - d)];
    return res;
  endfunction

  // monitor: drives outReady at the falling edge, samples 5 ns later
  always begin
    @(negedge clk);
    outReady <= holdReady ? 1'b0 : (jitter ? (($urandom % 4) != 0) : 1'b1);
    #5;
    if (outValid && outReady) begin
      pops++;
      popAt.push_back(cyc);
      if (expQ.size() == 0) begin
        check(0, "R8 unexpected result", outNextHop, -1);
      end else begin
        int e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(outNextHop == e[7:0] && outHit == (e != 0), t, outNextHop, e);
      end
    end
  end

  always @(posedge clk) cyc++;

  task automatic pushSlot();
    #6;
    while (!inReady) begin @(negedge clk); #6; end
    @(posedge clk);
  endtask

  task automatic goIdle();
    @(negedge clk);
    inValid = 0; inIsWrite = 0; wrEn = '0; nhaEn = 0;
  endtask

  task automatic lookup(int inst, int addr, int exp, string tag);
    @(negedge clk);
    inValid = 1; inIsWrite = 0; wrEn = '0; nhaEn = 0;
    inInst = inst[IW-1:0]; inAddr = addr[ADDR_W-1:0];
    expQ.push_back(exp); tagQ.push_back(tag);
    issued++;
    pushSlot();
  endtask

  // one route change as a single bubble; node words follow the R10 layout
  task automatic route(int inst, int d, int addr, int nh);
    int p, pk, b;
    bit [NODE_W-1:0] w;
    logic [STAGES-1:0] en;
    logic [STAGES*NAW-1:0] wa;
    logic [STAGES*NODE_W-1:0] wn;
    p = addr >> (STAGES - d);
    if (!hasIdx[d][p]) begin
      if (nextIdx >= NHA_DEPTH) return;
      hasIdx[d][p] = 1; idxOf[d][p] = nextIdx; nextIdx++;
    end
    en = '0; wa = '0; wn = '0;
    for (int k = 0; k <= d; k++) begin
      pk = p >> (d - k);
      w = shadow[k][pk];
      if (k < d) begin
        b = (p >> (d - k - 1)) & 1;
        if (b == 1) w[17] = 1'b1; else w[18] = 1'b1;
        w[16:10] = 7'((pk << 1) & 127);
      end else begin
        w[6 + inst] = (nh != 0);
        w[5:0] = 6'(idxOf[d][p]);
      end
      shadow[k][pk] = w;
      en[k] = 1'b1;
      wa[k*NAW +: NAW] = 7'(pk);
      wn[k*NODE_W +: NODE_W] = w;
    end
    rt[inst][d][p] = 8'(nh);
    @(negedge clk);
    inValid = 1; inIsWrite = 1; wrEn = en; wrAddr = wa; wrNode = wn;
    nhaEn = 1; nhaIdx = 6'(idxOf[d][p]); nhaInst = 2'(inst); nhaVal = 8'(nh);
    pushSlot();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, b, v1, seeds[8];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #5;
    check(outValid == 0, "R1 outValid after reset", outValid, 0);
    check(inReady == 1, "R1 inReady after reset", inReady, 1);

    // R6 latency on an empty trie (R1: miss)
    @(negedge clk);
    inValid = 1; inIsWrite = 0; inInst = 0; inAddr = 8'h33;
    expQ.push_back(0); tagQ.push_back("R1 empty trie");
    issued++;
    pushSlot();
    @(negedge clk); inValid = 0; n = 1; #5;
    while (!outValid) begin @(negedge clk); #5; n++; end
    check(n == STAGES + 1, "R6 latency", n, STAGES + 1);

    // vector table
    foreach (VECS[i]) begin
      if (VECS[i].isLookup)
        lookup(VECS[i].inst, VECS[i].addr, VECS[i].val, $sformatf("R%0d table %0d", VECS[i].req, i));
      else
        route(VECS[i].inst, VECS[i].len, VECS[i].addr, VECS[i].val);
    end
    goIdle();

    // R6 throughput: 16 back-to-back lookups
    b = popAt.size() + 1;  // the latency probe already popped at most once
    repeat (20) @(negedge clk);
    b = popAt.size();
    for (int i = 0; i < 16; i++) begin
      int a = $urandom % 256;
      lookup(i % 4, a, refLpm(i % 4, a), "R6 burst");
    end
    goIdle();
    repeat (14) @(negedge clk);
    check(popAt.size() == b + 16, "R6 burst count", popAt.size() - b, 16);
    if (popAt.size() >= b + 16)
      check(popAt[b+15] - popAt[b] == 15, "R6 consecutive", popAt[b+15] - popAt[b], 15);

    // R8 lone bubble gives no output
    b = pops;
    route(2, 2, 8'hC0, 55);
    goIdle();
    repeat (14) @(negedge clk);
    check(pops == b, "R8 bubble output", pops - b, 0);
    lookup(2, 8'hC5, 55, "R8 after lone bubble");
    // R8 race: lookup, bubble, lookup on consecutive cycles
    lookup(1, 8'h05, 0, "R8 before bubble");
    route(1, 1, 8'h00, 77);
    lookup(1, 8'h05, 77, "R8 after bubble");
    goIdle();
    repeat (14) @(negedge clk);

    // R9 output stall
    holdReady = 1;
    repeat (2) @(negedge clk);
    lookup(2, 8'hA8, 40, "R9 first stalled");
    lookup(0, 8'hA7, 20, "R9 second stalled");
    goIdle();
    repeat (14) @(negedge clk);
    #6;
    check(outValid == 1, "R9 valid held", outValid, 1);
    check(inReady == 0, "R9 ready low", inReady, 0);
    v1 = outNextHop;
    check(v1 == 40, "R9 stalled value", v1, 40);
    repeat (3) @(negedge clk);
    #6;
    check(outNextHop == v1[7:0] && outValid, "R9 stable", outNextHop, v1);
    holdReady = 0;
    repeat (6) @(negedge clk);

    // R7 random mix with jittered output ready
    jitter = 1;
    foreach (seeds[i]) seeds[i] = $urandom % 256;
    for (int i = 0; i < 400; i++) begin
      int r = $urandom % 10;
      int inst = $urandom % NUM_INST;
      if (r < 3) begin
        int nh = (($urandom % 8) == 0) ? 0 : 1 + ($urandom % 255);
        route(inst, $urandom % STAGES, seeds[$urandom % 8], nh);
      end else begin
        int a = (r < 7) ? (seeds[$urandom % 8] ^ ($urandom % 8)) : ($urandom % 256);
        lookup(inst, a, refLpm(inst, a), "R7 R2 random");
      end
    end
    goIdle();
    jitter = 0;
    n = 0;
    while (expQ.size() != 0 && n < 100) begin @(negedge clk); n++; end
    check(expQ.size() == 0, "R7 drained", expQ.size(), 0);
    check(pops == issued, "R8 one result per lookup", pops, issued);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule